// File: doc/BRIEF.md
# Banked Serial Port Register File

This block is the processor-side register window of an asynchronous serial controller. Eight byte-wide offsets are reached through a read strobe, a write strobe, a 3-bit offset and separate 8-bit write and read data buses. Behind them sit line control, interrupt enable, FIFO configuration, modem control and a scratch byte, plus a 16-bit baud divisor. Received bytes, line status and interrupt identification are presented on reads. The serializer, deserializer, FIFOs and baud generator live outside. This block drives their configuration and gives them one-cycle push, pop and clear strobes.

The top bit of the line control register banks offsets 0 and 1. When it is set, those offsets reach the low and high divisor bytes instead of the data and interrupt-enable registers. Offset 2 is write-only FIFO configuration on writes and interrupt identification on reads. Writes to the status offsets 5 and 6 are dropped. A divisor of 1 corresponds to 115200 baud (divisor = 115200 / baud). A line control value of 0x03 means 8 data bits, no parity and 1 stop bit.

Modem control bit 4 selects loopback. In loopback, a data write is diverted into a one-byte holder instead of the transmitter, and the next data read returns it. The holder is a two-state machine. `LB_EMPTY` goes to `LB_FULL` on a data write while loopback is on. `LB_FULL` stays in `LB_FULL` on a further data write, which overwrites the byte. `LB_FULL` returns to `LB_EMPTY` on a data read, or whenever loopback is switched off, which discards the held byte.

Read data is registered: `rdata` changes on the clock edge that samples `rd_en` and holds its value between reads. All push, pop and clear strobes are combinational from the access strobes in the same cycle, so the external FIFOs act on that same edge.

Top module: `usp_regfile`

## Requirements
- R1: After reset every stored register and the divisor are zero and all modem outputs are low. With `tx_room`=1 and `rx_avail`=0, offset 5 reads 0x20 and offset 2 reads 0x01.
- R2: With line control bit 7 set, offset 0 writes and reads the divisor low byte and offset 1 the high byte; `divisor` = {high, low}. A write to offset 0 then gives no `tx_push`.
- R3: With line control bit 7 clear and loopback off, a write to offset 0 gives `tx_push`=1 for that cycle only, with `tx_byte` equal to the written byte. A read of offset 0 returns `rx_data` and gives `rx_pop`=1 in that cycle when `rx_avail`=1.
- R4: With line control bit 7 clear, offset 1 is interrupt enable: bits 3:0 are stored and read back with bits 7:4 zero. The divisor is unaffected.
- R5: Offsets 3, 4, 6 and 7 are unaffected by bit 7. Line control reads back all 8 bits and drives `line_ctrl`. Modem control reads back bits 4:0 with bits 7:5 zero. Offset 6 reads `modem_status`. Scratch reads back all 8 bits.
- R6: A write to offset 2 stores bit 0 to `fifo_en` and bits 7:6 to `rx_trig`. Bits 1 and 2 raise `rx_clr` and `tx_clr` in the write cycle only and are not stored.
- R7: Offset 2 reads 0x01 when nothing is pending. It reads 0x04 when interrupt-enable bit 0 is set and data is ready; this outranks the next case. It reads 0x02 when interrupt-enable bit 1 is set and the transmit holding register is empty. Bits 7:6 read 11 while `fifo_en`=1.
- R8: Offset 5 reads bit 0 = data ready and bit 5 = transmit holding empty, with all other bits zero. Outside loopback these are `rx_avail` and `tx_room`.
- R9: In loopback, a data write fills the holder without `tx_push`. Offset 5 then reads 0x01. A read of offset 0 returns the held byte without `rx_pop` and empties the holder, after which offset 5 reads 0x20.
- R10: While loopback is on, `dtr`, `rts` and `out2` are held low. Outside loopback they follow modem control bits 0, 1 and 3.
- R11: Switching loopback off discards a held byte; re-entering loopback finds the holder empty.
- R12: `rdata` changes only on an edge where `rd_en` was high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_en | input | 1 | Read strobe, one cycle per access |
| wr_en | input | 1 | Write strobe, one cycle per access |
| addr | input | 3 | Register offset |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| rx_data | input | 8 | Head byte of the external receive FIFO |
| rx_avail | input | 1 | External receive FIFO holds data |
| tx_room | input | 1 | Transmit holding register can accept a byte |
| modem_status | input | 8 | Modem status byte shown at offset 6 |
| tx_push | output | 1 | Transmit byte push strobe |
| tx_byte | output | 8 | Byte to push |
| rx_pop | output | 1 | Receive FIFO pop strobe |
| rx_clr | output | 1 | Receive FIFO clear pulse |
| tx_clr | output | 1 | Transmit FIFO clear pulse |
| fifo_en | output | 1 | FIFO enable |
| rx_trig | output | 2 | Receive trigger level code |
| divisor | output | 16 | Baud divisor |
| line_ctrl | output | 8 | Line control register |
| dtr | output | 1 | Data terminal ready |
| rts | output | 1 | Request to send |
| out2 | output | 1 | Auxiliary output 2 |
| loop_en | output | 1 | Loopback active |

## Verification
The table pass runs the register map with the bank bit set and then cleared. Distinct byte values at offsets 0, 1, 3 and 7 show whether a write reached the wrong bank or the wrong offset. The directed part sweeps interrupt identification through no-pending, transmit-only, receive-only and both-pending inputs, which separates a wrong priority from a wrong enable. The loopback sequence fills, drains and abandons the holder while `rx_avail` is high, which exposes any leak of external pops or pushes into loopback. Strobes are probed inside and one cycle after each access, which distinguishes a pulse from a stored bit.

// File: rtl/usp_pkg.sv
package usp_pkg;
    localparam int REG_W     = 8;
    localparam int OFF_W     = 3;
    localparam int DIV_BYTES = 2;
    localparam int DIV_W     = REG_W * DIV_BYTES;
    localparam int IER_W     = 4;
    localparam int MCR_W     = 5;

    localparam logic [OFF_W-1:0] OFF_DATA = 3'd0;
    localparam logic [OFF_W-1:0] OFF_IEN  = 3'd1;
    localparam logic [OFF_W-1:0] OFF_IDF  = 3'd2;
    localparam logic [OFF_W-1:0] OFF_LCTL = 3'd3;
    localparam logic [OFF_W-1:0] OFF_MCTL = 3'd4;
    localparam logic [OFF_W-1:0] OFF_LST  = 3'd5;
    localparam logic [OFF_W-1:0] OFF_MST  = 3'd6;
    localparam logic [OFF_W-1:0] OFF_SCR  = 3'd7;

    localparam int BANK_BIT = 7;
    localparam int LOOP_BIT = 4;

    typedef enum logic [0:0] {
        LB_EMPTY = 1'b0,
        LB_FULL  = 1'b1
    } lb_state_t;
endpackage

// File: rtl/usp_cfg_regs.sv
module usp_cfg_regs
    import usp_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [OFF_W-1:0]     addr,
    input  logic [REG_W-1:0]     wdata,
    output logic [REG_W-1:0]     lcr,
    output logic [IER_W-1:0]     ier,
    output logic [MCR_W-1:0]     mcr,
    output logic [REG_W-1:0]     scr,
    output logic [DIV_W-1:0]     div_q,
    output logic                 fifo_en,
    output logic [1:0]           rx_trig,
    output logic                 rx_clr,
    output logic                 tx_clr
);
    logic bank;
    logic fcr_wr;

    assign bank   = lcr[BANK_BIT];
    assign fcr_wr = wr_en && (addr == OFF_IDF);
    assign rx_clr = fcr_wr && wdata[1];
    assign tx_clr = fcr_wr && wdata[2];

    for (genvar g = 0; g < DIV_BYTES; g++) begin : g_div
        always_ff @(posedge clk) begin
            if (!rst_n)
                div_q[g*REG_W +: REG_W] <= '0;
            else if (wr_en && bank && (addr == OFF_W'(g)))
                div_q[g*REG_W +: REG_W] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lcr     <= '0;
            ier     <= '0;
            mcr     <= '0;
            scr     <= '0;
            fifo_en <= 1'b0;
            rx_trig <= '0;
        end else if (wr_en) begin
            unique case (addr)
                OFF_IEN:  if (!bank) ier <= wdata[IER_W-1:0];
                OFF_IDF:  begin
                    fifo_en <= wdata[0];
                    rx_trig <= wdata[7:6];
                end
                OFF_LCTL: lcr <= wdata;
                OFF_MCTL: mcr <= wdata[MCR_W-1:0];
                OFF_SCR:  scr <= wdata;
                default:  ;
            endcase
        end
    end
endmodule

// File: rtl/usp_loop.sv
module usp_loop
    import usp_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             loop_on,
    input  logic             wr_stb,
    input  logic             rd_stb,
    input  logic [REG_W-1:0] wdata,
    output logic             held,
    output logic [REG_W-1:0] held_byte
);
    lb_state_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= LB_EMPTY;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LB_EMPTY: if (loop_on && wr_stb) state_d = LB_FULL;
            LB_FULL: begin
                if (!loop_on)     state_d = LB_EMPTY;
                else if (wr_stb)  state_d = LB_FULL;
                else if (rd_stb)  state_d = LB_EMPTY;
            end
            default: state_d = LB_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                held_byte <= '0;
        else if (loop_on && wr_stb) held_byte <= wdata;
    end

    assign held = (state_q == LB_FULL);
endmodule

// File: rtl/usp_rd_path.sv
module usp_rd_path
    import usp_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_en,
    input  logic [OFF_W-1:0] addr,
    input  logic [REG_W-1:0] lcr,
    input  logic [IER_W-1:0] ier,
    input  logic [MCR_W-1:0] mcr,
    input  logic [REG_W-1:0] scr,
    input  logic [DIV_W-1:0] div_q,
    input  logic             fifo_en,
    input  logic             held,
    input  logic [REG_W-1:0] held_byte,
    input  logic [REG_W-1:0] rx_data,
    input  logic             rx_avail,
    input  logic             tx_room,
    input  logic [REG_W-1:0] modem_status,
    output logic [REG_W-1:0] rdata
);
    logic             bank, loop_on, dr, thre;
    logic [REG_W-1:0] lsr, iir, mux;

    assign bank    = lcr[BANK_BIT];
    assign loop_on = mcr[LOOP_BIT];
    assign dr      = loop_on ? held  : rx_avail;
    assign thre    = loop_on ? !held : tx_room;
    assign lsr     = {2'b00, thre, 4'b0000, dr};

    always_comb begin
        iir = {fifo_en, fifo_en, 6'b000001};
        if (ier[0] && dr)        iir[3:0] = 4'b0100;
        else if (ier[1] && thre) iir[3:0] = 4'b0010;
    end

    always_comb begin
        mux = '0;
        unique case (addr)
            OFF_DATA: mux = bank ? div_q[REG_W-1:0] : (loop_on ? held_byte : rx_data);
            OFF_IEN:  mux = bank ? div_q[DIV_W-1:REG_W] : {{(REG_W-IER_W){1'b0}}, ier};
            OFF_IDF:  mux = iir;
            OFF_LCTL: mux = lcr;
            OFF_MCTL: mux = {{(REG_W-MCR_W){1'b0}}, mcr};
            OFF_LST:  mux = lsr;
            OFF_MST:  mux = modem_status;
            OFF_SCR:  mux = scr;
            default:  mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)     rdata <= '0;
        else if (rd_en) rdata <= mux;
    end
endmodule

// File: rtl/usp_regfile.sv
module usp_regfile
    import usp_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_en,
    input  logic             wr_en,
    input  logic [2:0]       addr,
    input  logic [7:0]       wdata,
    output logic [7:0]       rdata,
    input  logic [7:0]       rx_data,
    input  logic             rx_avail,
    input  logic             tx_room,
    input  logic [7:0]       modem_status,
    output logic             tx_push,
    output logic [7:0]       tx_byte,
    output logic             rx_pop,
    output logic             rx_clr,
    output logic             tx_clr,
    output logic             fifo_en,
    output logic [1:0]       rx_trig,
    output logic [15:0]      divisor,
    output logic [7:0]       line_ctrl,
    output logic             dtr,
    output logic             rts,
    output logic             out2,
    output logic             loop_en
);
    logic [IER_W-1:0] ier;
    logic [MCR_W-1:0] mcr;
    logic [REG_W-1:0] scr, held_byte;
    logic             held, data_sel, wr_data, rd_data;

    usp_cfg_regs u_cfg (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .lcr(line_ctrl), .ier(ier), .mcr(mcr), .scr(scr), .div_q(divisor),
        .fifo_en(fifo_en), .rx_trig(rx_trig), .rx_clr(rx_clr), .tx_clr(tx_clr)
    );

    assign loop_en  = mcr[LOOP_BIT];
    assign data_sel = (addr == OFF_DATA) && !line_ctrl[BANK_BIT];
    assign wr_data  = wr_en && data_sel;
    assign rd_data  = rd_en && data_sel;

    usp_loop u_loop (
        .clk(clk), .rst_n(rst_n), .loop_on(loop_en), .wr_stb(wr_data),
        .rd_stb(rd_data), .wdata(wdata), .held(held), .held_byte(held_byte)
    );

    usp_rd_path u_rd (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .addr(addr), .lcr(line_ctrl),
        .ier(ier), .mcr(mcr), .scr(scr), .div_q(divisor), .fifo_en(fifo_en),
        .held(held), .held_byte(held_byte), .rx_data(rx_data),
        .rx_avail(rx_avail), .tx_room(tx_room), .modem_status(modem_status),
        .rdata(rdata)
    );

    assign tx_push = wr_data && !loop_en;
    assign tx_byte = wdata;
    assign rx_pop  = rd_data && !loop_en && rx_avail;
    assign dtr     = mcr[0] && !loop_en;
    assign rts     = mcr[1] && !loop_en;
    assign out2    = mcr[3] && !loop_en;
endmodule

// File: rtl/usp_regfile_chk.sv
module usp_regfile_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        rd_en,
    input logic        wr_en,
    input logic [2:0]  addr,
    input logic [7:0]  wdata,
    input logic [7:0]  rdata,
    input logic        rx_avail,
    input logic        tx_push,
    input logic        rx_pop,
    input logic        fifo_en,
    input logic [15:0] divisor,
    input logic [7:0]  line_ctrl,
    input logic        dtr,
    input logic        rts,
    input logic        out2,
    input logic        loop_en
);
    // R2
    div_low_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 3'd0 && line_ctrl[7]) |=> (divisor[7:0] == $past(wdata)));

    // R3
    pop_normal_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_pop |-> (!loop_en && rx_avail && rd_en));

    // R6
    fifo_en_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(fifo_en));

    // R9
    no_push_in_loop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        loop_en |-> !tx_push);

    // R10
    modem_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        loop_en |-> (!dtr && !rts && !out2));

    // R12
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rdata));
endmodule

bind usp_regfile usp_regfile_chk u_chk (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .rx_avail(rx_avail), .tx_push(tx_push),
    .rx_pop(rx_pop), .fifo_en(fifo_en), .divisor(divisor),
    .line_ctrl(line_ctrl), .dtr(dtr), .rts(rts), .out2(out2), .loop_en(loop_en)
);

// File: tb/usp_regfile_bench.sv
module usp_regfile_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 17;
    // {write, offset, wdata, expected read}
    localparam logic [19:0] VEC [NVEC] = '{
        {1'b1, 3'd3, 8'h80, 8'h00},
        {1'b1, 3'd0, 8'h34, 8'h00},
        {1'b1, 3'd1, 8'h12, 8'h00},
        {1'b0, 3'd0, 8'h00, 8'h34},
        {1'b0, 3'd1, 8'h00, 8'h12},
        {1'b0, 3'd3, 8'h00, 8'h80},
        {1'b1, 3'd3, 8'h03, 8'h00},
        {1'b1, 3'd1, 8'h05, 8'h00},
        {1'b0, 3'd1, 8'h00, 8'h05},
        {1'b0, 3'd3, 8'h00, 8'h03},
        {1'b1, 3'd7, 8'hA5, 8'h00},
        {1'b0, 3'd7, 8'h00, 8'hA5},
        {1'b1, 3'd4, 8'hE3, 8'h00},
        {1'b0, 3'd4, 8'h00, 8'h03},
        {1'b0, 3'd6, 8'h00, 8'h5A},
        {1'b0, 3'd5, 8'h00, 8'h20},
        {1'b0, 3'd2, 8'h00, 8'h01}
    };

    logic clk = 1'b0, rst_n = 1'b0, rd_en = 1'b0, wr_en = 1'b0;
    logic [2:0]  addr = '0;
    logic [7:0]  wdata = '0, rx_data = '0, modem_status = 8'h5A;
    logic        rx_avail = 1'b0, tx_room = 1'b1;
    logic [7:0]  rdata, tx_byte, line_ctrl;
    logic        tx_push, rx_pop, rx_clr, tx_clr, fifo_en, dtr, rts, out2, loop_en;
    logic [1:0]  rx_trig;
    logic [15:0] divisor;

    int n_chk = 0, n_bad = 0;
    logic done = 1'b0;
    logic s_push, s_rxclr, s_txclr, s_pop, a_push, a_rxclr, a_txclr, a_pop;
    logic [7:0] s_byte, rv, hold_v;

    always #(CLK_PERIOD/2) clk = ~clk;

    usp_regfile u_usp_regfile (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .rx_data(rx_data), .rx_avail(rx_avail),
        .tx_room(tx_room), .modem_status(modem_status), .tx_push(tx_push),
        .tx_byte(tx_byte), .rx_pop(rx_pop), .rx_clr(rx_clr), .tx_clr(tx_clr),
        .fifo_en(fifo_en), .rx_trig(rx_trig), .divisor(divisor),
        .line_ctrl(line_ctrl), .dtr(dtr), .rts(rts), .out2(out2), .loop_en(loop_en)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        #1;
        s_push = tx_push; s_byte = tx_byte; s_rxclr = rx_clr; s_txclr = tx_clr;
        @(negedge clk);
        wr_en = 1'b0;
        #1;
        a_push = tx_push; a_rxclr = rx_clr; a_txclr = tx_clr;
    endtask

    task automatic do_rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        #1;
        s_pop = rx_pop;
        @(negedge clk);
        rd_en = 1'b0;
        #1;
        a_pop = rx_pop;
        d = rdata;
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        chk("R1 divisor", divisor, 16'h0000);
        chk("R1 modem pins", {13'b0, dtr, rts, out2}, 16'h0);
        do_rd(3'd5, rv); chk("R1 line status", rv, 8'h20);
        do_rd(3'd2, rv); chk("R1 int id", rv, 8'h01);
        do_rd(3'd3, rv); chk("R1 line ctrl", rv, 8'h00);
        do_rd(3'd7, rv); chk("R1 scratch", rv, 8'h00);

        // R2 R4 R5 R8 R7 table walk
        for (int i = 0; i < NVEC; i++) begin
            if (VEC[i][19]) do_wr(VEC[i][18:16], VEC[i][15:8]);
            else begin
                do_rd(VEC[i][18:16], rv);
                chk($sformatf("R5 table entry %0d", i), rv, VEC[i][7:0]);
            end
        end
        chk("R2 divisor output", divisor, 16'h1234);
        chk("R5 line_ctrl output", line_ctrl, 16'h0003);
        chk("R10 modem pins normal", {13'b0, dtr, rts, out2}, 16'h6);

        // R3 transmit push
        do_wr(3'd0, 8'h41);
        chk("R3 push in cycle", s_push, 1'b1);
        chk("R3 push byte", s_byte, 8'h41);
        chk("R3 push one cycle", a_push, 1'b0);
        chk("R4 divisor untouched by data write", divisor, 16'h1234);

        // R3 receive pop, R8 data ready
        rx_avail = 1'b1; rx_data = 8'h77;
        do_rd(3'd5, rv); chk("R8 status data ready", rv, 8'h21);
        do_rd(3'd0, rv);
        chk("R3 rx data", rv, 8'h77);
        chk("R3 pop in cycle", s_pop, 1'b1);
        chk("R3 pop one cycle", a_pop, 1'b0);

        // R7 interrupt identification
        do_rd(3'd2, rv); chk("R7 rx pending", rv, 8'h04);
        do_wr(3'd1, 8'h03);
        chk("R4 divisor untouched by ier write", divisor, 16'h1234);
        do_rd(3'd2, rv); chk("R7 rx outranks tx", rv, 8'h04);
        rx_avail = 1'b0;
        do_rd(3'd2, rv); chk("R7 tx pending", rv, 8'h02);
        tx_room = 1'b0;
        do_rd(3'd2, rv); chk("R7 none pending", rv, 8'h01);
        do_rd(3'd5, rv); chk("R8 status busy", rv, 8'h00);
        tx_room = 1'b1;

        // R6 FIFO control
        do_wr(3'd2, 8'hC7);
        chk("R6 clear pulses in cycle", {s_rxclr, s_txclr}, 2'b11);
        chk("R6 clear pulses gone", {a_rxclr, a_txclr}, 2'b00);
        chk("R6 fifo_en", fifo_en, 1'b1);
        chk("R6 trigger", rx_trig, 2'd3);
        do_rd(3'd2, rv); chk("R7 fifo bits in id", rv, 8'hC2);
        do_wr(3'd2, 8'h40);
        chk("R6 no clears", {s_rxclr, s_txclr}, 2'b00);
        chk("R6 fifo off and trigger", {fifo_en, rx_trig}, 3'b001);

        // R2 no push while banked
        do_wr(3'd3, 8'h83);
        do_wr(3'd0, 8'h99);
        chk("R2 no push when banked", s_push, 1'b0);
        chk("R2 low byte reload", divisor, 16'h1299);
        do_wr(3'd3, 8'h03);

        // R9 R10 loopback
        do_wr(3'd4, 8'h13);
        chk("R10 modem pins quiet", {13'b0, dtr, rts, out2}, 16'h0);
        chk("R9 loop_en", loop_en, 1'b1);
        rx_avail = 1'b1; rx_data = 8'h11;
        do_rd(3'd5, rv); chk("R9 empty holder status", rv, 8'h20);
        do_wr(3'd0, 8'hAE);
        chk("R9 no push in loopback", s_push, 1'b0);
        do_rd(3'd5, rv); chk("R9 full holder status", rv, 8'h01);
        do_rd(3'd0, rv);
        chk("R9 loop byte", rv, 8'hAE);
        chk("R9 no pop in loopback", s_pop, 1'b0);
        do_rd(3'd5, rv); chk("R9 drained status", rv, 8'h20);

        // R11 leaving loopback flushes
        do_wr(3'd0, 8'h55);
        do_wr(3'd4, 8'h03);
        rx_avail = 1'b0;
        do_rd(3'd5, rv); chk("R11 normal after exit", rv, 8'h20);
        do_wr(3'd4, 8'h10);
        do_rd(3'd5, rv); chk("R11 holder flushed", rv, 8'h20);
        do_wr(3'd4, 8'h00);

        // R12 rdata holds without a read
        do_rd(3'd7, rv);
        hold_v = rdata;
        do_wr(3'd7, 8'h3C);
        repeat (3) @(negedge clk);
        chk("R12 rdata held", rdata, hold_v);
        do_rd(3'd7, rv); chk("R12 rdata updates on read", rv, 8'h3C);

        // R1 mid-run reset
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        chk("R1 divisor after reset", divisor, 16'h0000);
        chk("R1 fifo cfg after reset", {fifo_en, rx_trig}, 3'b000);
        do_rd(3'd7, rv); chk("R1 scratch after reset", rv, 8'h00);

        done = 1'b1;
        summary();
    end
endmodule